// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block is a bank of hardware semaphores on a memory-mapped register port, shared by several processors that need mutual exclusion. Every lock occupies one 32-bit word. A read of a lock word is an atomic test-and-set: it returns the state the lock had and leaves the lock held, all in one access. A processor whose read returns 0 owns the lock. A processor whose read returns 1 must retry later. The owner frees the lock by writing 0 to the same word.

A read-only status word gives the bank size as a count of 32-lock groups, so software can find the lock count at start-up. The port carries one access per clock. Read data is registered and appears in the cycle after the read strobe.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset every lock is free, and `rd_data` is 0x0000_0000.
- R2: A read of a free lock returns 0x0000_0000 on `rd_data` one cycle after the strobe and leaves that lock held.
- R3: A read of a held lock returns 0x0000_0001 and leaves the lock held.
- R4: A write of 0x0000_0000 to a lock word frees that lock, so the next read of it returns 0.
- R5: A write of any nonzero value to a lock word leaves that lock's state unchanged.
- R6: Lock i sits at byte address 0x800 + 4*i. The number of locks is 32*SIZE_UNITS, where SIZE_UNITS is 1, 2, 4 or 8.
- R7: Reads of the following addresses return 0x0000_0001 and change no lock: unaligned addresses (low two bits not 00), addresses outside every mapped word, and lock indices at or above the lock count. Writes to these addresses have no effect.
- R8: A read of byte address 0x014 returns SIZE_UNITS in bits [31:24] and 0 in bits [23:0]. Writes to this address have no effect.
- R9: When a read and a write of 0 reach the same lock in the same cycle, the write takes effect first. The read returns 0 and the lock ends up held.
- R10: `rd_data` keeps its last value during cycles with no read strobe.
- R11: An access to one lock never changes any other lock, and at most one lock changes state per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | ADDR_W | Byte address of the access |
| rd_en | input | 1 | Read strobe; performs the test-and-set on a lock word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; 0 releases a lock |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |

## Verification
The embedded properties check on every cycle that a lock read leaves the lock held, that a lone write of 0 frees the lock, and that a lone nonzero write leaves the lock unchanged. They also check that unmapped accesses and status accesses leave the lock vector untouched, that the status word reads correctly, and that no cycle changes more than one lock. Some behaviour can only be shown by the bench's scenarios through the port:
- the value each read returns, given the history of claims and releases;
- the ordering when a read and a write arrive together;
- the boundary between the last mapped lock and the first unmapped index;
- the holding of `rd_data` between reads.

// File: rtl/hw_sem_bank.sv
module hw_sem_bank #(
  parameter int SIZE_UNITS = 1,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  localparam int NUM_LOCKS = 32 * SIZE_UNITS;
  localparam int IDX_W     = $clog2(NUM_LOCKS);
  localparam int LOCK_BASE = 'h800;
  localparam int LOCK_END  = LOCK_BASE + 4 * NUM_LOCKS;
  localparam int STAT_OFS  = 'h14;
  localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(LOCK_BASE);
  localparam logic [ADDR_W:0] END_A  = (ADDR_W+1)'(LOCK_END);
  localparam logic [31:0] STAT_WORD  = {8'(SIZE_UNITS), 24'h0};

  logic [NUM_LOCKS-1:0] held;
  logic [ADDR_W:0]      addr_x, offs;
  logic [IDX_W-1:0]     idx;
  logic                 lk_hit, stat_hit, rel, cur;

  assign addr_x   = {1'b0, acc_addr};
  assign offs     = addr_x - BASE_A;
  assign idx      = offs[IDX_W+1:2];
  assign lk_hit   = (addr_x >= BASE_A) && (addr_x < END_A) && (acc_addr[1:0] == 2'b00);
  assign stat_hit = (acc_addr == ADDR_W'(STAT_OFS));
  assign rel      = wr_en && lk_hit && (wr_data == 32'h0);
  assign cur      = held[idx] && !rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      rd_data <= '0;
    end else begin
      if (rel)            held[idx] <= 1'b0;
      if (rd_en && lk_hit) held[idx] <= 1'b1;
      if (rd_en) begin
        if (stat_hit)    rd_data <= STAT_WORD;
        else if (lk_hit) rd_data <= {31'h0, cur};
        else             rd_data <= 32'h1;
      end
    end
  end

  p_claim_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && lk_hit) |=> held[$past(idx)]);
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !rd_en) |=> !held[$past(idx)]);
  p_nonzero_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && lk_hit && wr_data != 32'h0) |=> held[$past(idx)] == $past(held[idx]));
  p_unmapped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_hit) |=> $stable(held));
  p_status_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_hit) |=> (rd_data[31:24] == 8'(SIZE_UNITS)) && (rd_data[23:0] == 24'h0));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rd_data));
  p_one_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(held ^ $past(held)) <= 1);
endmodule

// File: tb/hw_sem_bank_tb.sv
module hw_sem_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] acc_addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hw_sem_bank #(.SIZE_UNITS(1), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input logic r, input logic w,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    acc_addr = a; rd_en = r; wr_en = w; wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    q = rd_data;
  endtask

  function automatic logic [11:0] la(int i);
    return 12'(32'h800 + 4 * i);
  endfunction

  task automatic t_reset();
    logic [31:0] q;
    chk("R1 rd_data after reset", rd_data, 32'h0);
    for (int i = 0; i < 32; i += 9) begin
      acc(la(i), 1, 0, 0, q);
      chk("R1 lock free after reset", q, 32'h0);
      acc(la(i), 0, 1, 0, q);
    end
  endtask

  task automatic t_claim();
    logic [31:0] q;
    acc(la(3), 1, 0, 0, q); chk("R2 claim free lock", q, 32'h0);
    acc(la(3), 1, 0, 0, q); chk("R3 read held lock", q, 32'h1);
    acc(la(3), 1, 0, 0, q); chk("R3 held stays held", q, 32'h1);
  endtask

  task automatic t_release();
    logic [31:0] q;
    acc(la(3), 0, 1, 32'h0, q);
    acc(la(3), 1, 0, 0, q); chk("R4 write 0 frees", q, 32'h0);
  endtask

  task automatic t_nonzero();
    logic [31:0] q;
    acc(la(3), 0, 1, 32'hFFFF_FFFE, q);
    acc(la(3), 1, 0, 0, q); chk("R5 nonzero write keeps held", q, 32'h1);
    acc(la(3), 0, 1, 32'h0, q);
    acc(la(3), 0, 1, 32'h1, q);
    acc(la(3), 1, 0, 0, q); chk("R5 nonzero write keeps free", q, 32'h0);
    acc(la(3), 0, 1, 32'h0, q);
  endtask

  task automatic t_map();
    logic [31:0] q;
    acc(la(31), 1, 0, 0, q); chk("R6 last lock claimable", q, 32'h0);
    acc(la(31), 1, 0, 0, q); chk("R6 last lock held", q, 32'h1);
    acc(la(32), 1, 0, 0, q); chk("R6 index past count unmapped", q, 32'h1);
    acc(la(32), 1, 0, 0, q); chk("R7 unmapped read repeats 1", q, 32'h1);
    acc(la(31), 0, 1, 0, q);
  endtask

  task automatic t_unmapped();
    logic [31:0] q;
    acc(la(5) + 12'd2, 1, 0, 0, q); chk("R7 unaligned read", q, 32'h1);
    acc(la(5), 1, 0, 0, q); chk("R7 unaligned read left lock free", q, 32'h0);
    acc(12'h7FC, 1, 0, 0, q); chk("R7 below window", q, 32'h1);
    acc(la(5) + 12'd1, 0, 1, 32'h0, q);
    acc(la(5), 1, 0, 0, q); chk("R7 unaligned write ignored", q, 32'h1);
    acc(la(5), 0, 1, 0, q);
  endtask

  task automatic t_status();
    logic [31:0] q;
    acc(12'h014, 1, 0, 0, q); chk("R8 status word", q, 32'h0100_0000);
    acc(12'h014, 0, 1, 32'h0800_0000, q);
    acc(12'h014, 1, 0, 0, q); chk("R8 status write ignored", q, 32'h0100_0000);
  endtask

  task automatic t_same_cycle();
    logic [31:0] q;
    acc(la(7), 1, 0, 0, q);
    acc(la(7), 1, 1, 32'h0, q); chk("R9 write-then-read returns 0", q, 32'h0);
    acc(la(7), 1, 0, 0, q); chk("R9 lock held after", q, 32'h1);
    acc(la(7), 0, 1, 0, q);
  endtask

  task automatic t_hold();
    logic [31:0] q;
    acc(la(9), 1, 0, 0, q);
    acc(la(9), 1, 0, 0, q);
    repeat (3) @(negedge clk);
    chk("R10 rd_data holds", rd_data, 32'h1);
    acc(la(9), 0, 1, 0, q); chk("R10 write keeps rd_data", q, 32'h1);
  endtask

  task automatic t_indep();
    logic [31:0] q;
    acc(la(10), 1, 0, 0, q);
    acc(la(11), 1, 0, 0, q); chk("R11 neighbour unaffected by claim", q, 32'h0);
    acc(la(10), 0, 1, 0, q);
    acc(la(11), 1, 0, 0, q); chk("R11 neighbour unaffected by release", q, 32'h1);
    acc(la(10), 1, 0, 0, q); chk("R11 released lock free", q, 32'h0);
    acc(la(10), 0, 1, 0, q);
    acc(la(11), 0, 1, 0, q);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_claim();
    t_release();
    t_nonzero();
    t_map();
    t_unmapped();
    t_status();
    t_same_cycle();
    t_hold();
    t_indep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule